// File: doc/BRIEF.md
# Key-protected system control registers

This block is a small memory-mapped register file holding two system control words. The first is a table base word: it places an exception vector table anywhere in memory on a 256-byte boundary. The second is a guarded control word: it carries the interrupt priority grouping setting. A write to the guarded word only takes effect when its upper halfword carries a fixed unlock key. Every read of that word returns the key constant in the same upper halfword.

The register bus is a plain synchronous port with an address, write enable, write data, read enable and read data. Every access completes in one cycle, so the port has no back-pressure and no ready signal. Read data is registered and appears in the cycle after the read strobe. The port reads as zero in any cycle without a read. A one-cycle acknowledge pulse follows each write that changed a register.

Three outputs go to the rest of the system and follow the stored values at all times: the aligned table base, a flag for the code or SRAM region, and the grouping field.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, tbl_base, in_sram, prigroup, rd_data and wr_ack are all zero.
- R2: Any write to byte address 0x08 (the table base word) stores wr_data[29:8] on that clock edge, with no key needed. tbl_base then equals {2'b00, stored bits, 8'h00}.
- R3: A read of address 0x08 returns the stored bits in [29:8]. Bits [31:30] and [7:0] read as zero whatever was written, so the base is always 256-byte aligned.
- R4: in_sram equals bit 29 of the stored base: 0 selects the code region and 1 selects the SRAM region.
- R5: A write to byte address 0x0C (the guarded word) with wr_data[31:16] == 16'h05FA loads prigroup from wr_data[10:8].
- R6: A write to 0x0C with any other value in wr_data[31:16] is ignored. Nothing changes and no acknowledge pulse is produced.
- R7: A read of 0x0C returns 16'h05FA in [31:16], 0 in bit 15 (little-endian), zeros in [14:11] and [7:0], and prigroup in [10:8].
- R8: Reads of any address other than 0x08 and 0x0C return zero. Writes to them change no state.
- R9: wr_ack is high for exactly the one cycle after a write that updated a register, and low otherwise.
- R10: rd_data holds the value read in the cycle after rd_en, and zero in the cycle after a cycle without rd_en. A read made in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| wr_ack | output | 1 | One-cycle pulse after an accepted write |
| tbl_base | output | 32 | Aligned vector table base |
| in_sram | output | 1 | Table region flag: 1 selects SRAM, 0 selects code |
| prigroup | output | 3 | Priority grouping field |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address, a 16-bit key of 0x05FA, and a 3-bit grouping field. Addresses are drawn over the whole 8-bit space, so unmapped and misaligned addresses come up often beside the two mapped words. About a quarter of the random guarded-word writes carry the correct key, so both accepted and rejected writes occur many times. Directed cases cover all-ones data, a near-miss key, and a read made in the same cycle as a write.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_BASE = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/scr_base_reg.sv
module scr_base_reg #(
  parameter int DW    = 32,
  parameter int LO    = 8,
  parameter int HI    = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [HI:LO]  field_q,
  output logic [DW-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  field_q <= '0;
    else if (we) field_q <= wdata[HI:LO];
  end

  always_comb begin
    base        = '0;
    base[HI:LO] = field_q;
  end
endmodule

// File: rtl/scr_ctrl_reg.sv
module scr_ctrl_reg #(
  parameter int                DW    = 32,
  parameter int                KEY_W = 16,
  parameter logic [KEY_W-1:0]  KEY   = 16'h05FA,
  parameter int                PG_W  = 3,
  parameter int                PG_LO = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  output logic            key_ok,
  output logic [PG_W-1:0] pg_q
);
  localparam int KEY_LO = DW - KEY_W;

  assign key_ok = (wdata[DW-1:KEY_LO] == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pg_q <= '0;
    else if (we && key_ok) pg_q <= wdata[PG_LO+PG_W-1:PG_LO];
  end
endmodule

// File: rtl/scr_readmux.sv
module scr_readmux
  import scr_pkg::*;
#(
  parameter int               DW    = 32,
  parameter int               KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY   = 16'h05FA,
  parameter int               PG_W  = 3,
  parameter int               PG_LO = 8
) (
  input  reg_sel_e        sel,
  input  logic [DW-1:0]   base,
  input  logic [PG_W-1:0] pg,
  output logic [DW-1:0]   rdata
);
  localparam int KEY_LO = DW - KEY_W;

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_BASE: rdata = base;
      SEL_CTRL: begin
        rdata[DW-1:KEY_LO]          = KEY;
        rdata[PG_LO+PG_W-1:PG_LO]   = pg;
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import scr_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DW        = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C,
  parameter int                KEY_W     = 16,
  parameter logic [KEY_W-1:0]  KEY       = 16'h05FA,
  parameter int                PG_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              wr_ack,
  output logic [DW-1:0]     tbl_base,
  output logic              in_sram,
  output logic [PG_W-1:0]   prigroup
);
  localparam int BASE_LO = 8;
  localparam int BASE_HI = 29;
  localparam int PG_LO   = 8;

  reg_sel_e             sel;
  logic                 key_ok;
  logic [BASE_HI:BASE_LO] base_field;
  logic [DW-1:0]        rd_next;

  always_comb begin
    if (addr == BASE_ADDR)      sel = SEL_BASE;
    else if (addr == CTRL_ADDR) sel = SEL_CTRL;
    else                        sel = SEL_NONE;
  end

  scr_base_reg #(.DW(DW), .LO(BASE_LO), .HI(BASE_HI)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en && (sel == SEL_BASE)),
    .wdata  (wr_data),
    .field_q(base_field),
    .base   (tbl_base)
  );

  scr_ctrl_reg #(.DW(DW), .KEY_W(KEY_W), .KEY(KEY), .PG_W(PG_W), .PG_LO(PG_LO)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && (sel == SEL_CTRL)),
    .wdata (wr_data),
    .key_ok(key_ok),
    .pg_q  (prigroup)
  );

  scr_readmux #(.DW(DW), .KEY_W(KEY_W), .KEY(KEY), .PG_W(PG_W), .PG_LO(PG_LO)) u_rmux (
    .sel  (sel),
    .base (tbl_base),
    .pg   (prigroup),
    .rdata(rd_next)
  );

  assign in_sram = base_field[BASE_HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      wr_ack  <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_next : '0;
      wr_ack  <= wr_en && ((sel == SEL_BASE) || ((sel == SEL_CTRL) && key_ok));
    end
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DW        = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C,
  parameter int                KEY_W     = 16,
  parameter logic [KEY_W-1:0]  KEY       = 16'h05FA,
  parameter int                PG_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic [DW-1:0]     rd_data,
  input logic              wr_ack,
  input logic [DW-1:0]     tbl_base,
  input logic              in_sram,
  input logic [PG_W-1:0]   prigroup
);
  localparam int KEY_LO = DW - KEY_W;

  logic mapped;
  assign mapped = (addr == BASE_ADDR) || (addr == CTRL_ADDR);

  assert_base_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BASE_ADDR) |=> (tbl_base[29:8] == $past(wr_data[29:8])));

  assert_base_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == BASE_ADDR) |=> (rd_data[31:30] == 2'b00 && rd_data[7:0] == 8'h00));

  assert_region_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BASE_ADDR) |=> (in_sram == $past(wr_data[29])));

  assert_key_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR && wr_data[DW-1:KEY_LO] == KEY) |=> (prigroup == $past(wr_data[10:8])));

  assert_key_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR && wr_data[DW-1:KEY_LO] != KEY) |=> ($stable(prigroup) && !wr_ack));

  assert_ctrl_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == CTRL_ADDR) |=> (rd_data[DW-1:KEY_LO] == KEY && rd_data[15:11] == 5'd0 && rd_data[7:0] == 8'd0));

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |=> ($stable(tbl_base) && $stable(prigroup) && !wr_ack));

  assert_ack_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(wr_en));

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> (rd_data == '0));
endmodule

bind sysctl_regs sysctl_regs_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(CTRL_ADDR),
  .KEY_W(KEY_W), .KEY(KEY), .PG_W(PG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .wr_ack(wr_ack), .tbl_base(tbl_base),
  .in_sram(in_sram), .prigroup(prigroup)
);

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_BASE = 8'h08;
  localparam logic [7:0] A_CTRL = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        wr_ack;
  logic [31:0] tbl_base;
  logic        in_sram;
  logic [2:0]  prigroup;

  int n_checks = 0;
  int n_fail   = 0;
  logic [21:0] m_off = '0;
  logic [2:0]  m_pg  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .wr_ack(wr_ack), .tbl_base(tbl_base),
    .in_sram(in_sram), .prigroup(prigroup)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == A_BASE)      return {2'b00, m_off, 8'h00};
    else if (a == A_CTRL) return {16'h05FA, 1'b0, 4'b0000, m_pg, 8'h00};
    else                  return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " tbl_base"}, tbl_base, {2'b00, m_off, 8'h00});
    check({req, " in_sram"}, {31'd0, in_sram}, {31'd0, m_off[21]});
    check({req, " prigroup"}, {29'd0, prigroup}, {29'd0, m_pg});
  endtask

  // write only; checks ack and state in the following cycle
  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
    logic accepted;
    accepted = (a == A_BASE) || (a == A_CTRL && d[31:16] == 16'h05FA);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == A_BASE) m_off = d[29:8];
    else if (accepted) m_pg = d[10:8];
    check({req, " R9 wr_ack"}, {31'd0, wr_ack}, {31'd0, accepted});
    check_outputs(req);
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    check({req, " rd_data"}, rd_data, exp_read(a));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] old_rd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 wr_ack", {31'd0, wr_ack}, 32'h0);
    check_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle rd_data", rd_data, 32'h0);

    // R2 R3 R4 directed
    do_write(A_BASE, 32'hFFFF_FFFF, "R2 all-ones");
    do_read(A_BASE, "R3 masked read");
    check("R4 sram flag", {31'd0, in_sram}, 32'd1);
    do_write(A_BASE, 32'h1FFF_FF00, "R4 code region");
    check("R4 code flag", {31'd0, in_sram}, 32'd0);

    // R5 R6 R7 directed
    do_write(A_CTRL, 32'h05FA_0500, "R5 keyed write");
    do_read(A_CTRL, "R7 ctrl read");
    do_write(A_CTRL, 32'h05FB_0300, "R6 near-miss key");
    do_write(A_CTRL, 32'h0000_0700, "R6 zero key");
    do_write(A_CTRL, 32'h05FA_FFFF, "R5 keyed all-ones");
    do_read(A_CTRL, "R7 reserved zero");

    // R8 unmapped
    do_write(8'h09, 32'h05FA_0000, "R8 misaligned write");
    do_read(8'h10, "R8 unmapped read");

    // R10 same-cycle read and write returns old value
    old_rd = exp_read(A_BASE);
    @(negedge clk);
    addr = A_BASE; wr_data = 32'h2000_1200; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    m_off = 22'h20_0012;
    check("R10 read-before-write", rd_data, old_rd);
    check("R10 R9 ack", {31'd0, wr_ack}, 32'd1);
    @(negedge clk);
    check("R10 idle after read", rd_data, 32'h0);
    check("R9 ack pulse ends", {31'd0, wr_ack}, 32'd0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 3);
      a = (pick == 0) ? A_BASE : (pick == 1) ? A_CTRL : 8'($urandom);
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d[31:16] = 16'h05FA;
      if ($urandom_range(0, 1) == 0) do_write(a, d, "R2/R5/R6/R8 random write");
      else                           do_read(a, "R3/R7/R8 random read");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule